// File: doc/BRIEF.md
# Region-Granular Drowsy Cache Controller

This block decides when each part of a cache data array sits at its low-leakage retention voltage and when it is raised to full supply. The array is carved into regions, each a power-of-two run of neighbouring blocks. A single access to any block brings its whole region up, so later accesses to nearby lines pay nothing. Each region keeps its own state: drowsy, waking or awake.

A requester presents a block index with a valid strobe. If the region is awake, ready answers in the same cycle. If it is drowsy, the controller raises that region's supply enable at once and holds ready low for a fixed wake-up latency. The requester keeps the request up until ready is seen. Every awake region counts the cycles in which it is not touched. Once that count reaches a threshold set on an input, the region falls back to drowsy. A global override keeps every region at full supply. Two counters report how many wake-ups were started and how many cycles were stalled.

Top module: `drowsy_region_ctrl`

## Requirements
- R1: After reset every region is drowsy, every supply enable is 0, both event counters are 0, and ready is 0 for any block while the override is low.
- R2: The region of a block is its block index shifted right by log2(REGION_BLOCKS). Waking a region for one block makes every other block of the same region ready with no stall, and it leaves blocks of the next region unaffected.
- R3: A request to a drowsy region keeps ready low for exactly WAKE_LAT cycles, counted from the cycle the request first appears. That region's supply enable reads 1 from the next cycle onward.
- R4: A request to an awake region sees ready high in the same cycle.
- R5: Further cycles of a request to a region that is already waking, including a switch to another block of the same region, do not restart the wake-up, so the total stall stays WAKE_LAT.
- R6: An awake region whose last access was accepted in cycle a is still awake through cycle a+idle_limit and is drowsy, with its supply enable at 0, from cycle a+idle_limit+1. Every accepted access restarts this count.
- R7: An idle_limit of 0 disables decay, so an awake region stays awake however long it stays idle.
- R8: While force_awake is 1, all supply enables read 1, every request is ready in the same cycle, and every region holds as awake with a cleared idle count. After release, the regions are awake and decay normally.
- R9: wake_count rises by one for each wake-up started by a request. stall_count rises by one for each cycle with req_valid high and req_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_block | input | $clog2(NUM_BLOCKS) | Block index of the access |
| req_ready | output | 1 | Access may complete this cycle |
| force_awake | input | 1 | Keep every region at full supply |
| idle_limit | input | IDLE_W | Idle cycles before decay; 0 disables decay |
| region_vdd_en | output | NUM_BLOCKS/REGION_BLOCKS | Per-region full-supply enable |
| wake_count | output | CNT_W | Wake-ups started by requests |
| stall_count | output | CNT_W | Cycles with a stalled request |

## Verification
The embedded properties assume that a stalled requester keeps req_valid high, and stays inside the same region, until it sees ready. The stall and no-restart checks rest on that assumption. They also assume that idle_limit changes only while no region depends on its count. The bench driver only lowers valid after ready has been sampled high. Its one mid-stall change of block index stays within the region being woken. It changes idle_limit and force_awake only between requests.

// File: rtl/drowsy_pkg.sv
package drowsy_pkg;
   typedef enum logic [1:0] {
      RG_DROWSY = 2'd0,
      RG_WAKING = 2'd1,
      RG_AWAKE  = 2'd2
   } rg_state_e;
endpackage

// File: rtl/drowsy_region_map.sv
module drowsy_region_map #(
   parameter int BLK_W = 6,
   parameter int OFS_W = 3,
   localparam int RG_W  = BLK_W - OFS_W,
   localparam int NRG   = 1 << RG_W
) (
   input  logic [BLK_W-1:0] block_i,
   input  logic             valid_i,
   output logic [RG_W-1:0]  region_o,
   output logic [NRG-1:0]   select_o
);
   assign region_o = block_i[BLK_W-1:OFS_W];

   for (genvar r = 0; r < NRG; r++) begin : g_sel
      assign select_o[r] = valid_i && (region_o == RG_W'(r));
   end

   if (OFS_W > 0) begin : g_ofs
      logic [OFS_W-1:0] unused_ofs;
      assign unused_ofs = block_i[OFS_W-1:0];
   end
endmodule

// File: rtl/drowsy_region_slot.sv
module drowsy_region_slot
   import drowsy_pkg::*;
#(
   parameter int WAKE_LAT = 2,
   parameter int IDLE_W   = 16,
   localparam int WW      = $clog2(WAKE_LAT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              force_i,
   input  logic [IDLE_W-1:0] limit_i,
   output logic              vdd_en_o,
   output logic              awake_o,
   output logic              wake_start_o
);
   rg_state_e         state;
   logic [WW-1:0]     wcnt;
   logic [IDLE_W-1:0] idle;
   logic [IDLE_W:0]   idle_nx;
   logic              hit;

   assign awake_o      = (state == RG_AWAKE);
   assign vdd_en_o     = (state != RG_DROWSY) || force_i;
   assign hit          = sel_i && awake_o;
   assign wake_start_o = sel_i && (state == RG_DROWSY) && !force_i;
   assign idle_nx      = {1'b0, idle} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RG_DROWSY;
         wcnt  <= '0;
         idle  <= '0;
      end else if (force_i) begin
         state <= RG_AWAKE;
         wcnt  <= '0;
         idle  <= '0;
      end else begin
         case (state)
            RG_DROWSY: begin
               if (sel_i) begin
                  state <= (WAKE_LAT == 1) ? RG_AWAKE : RG_WAKING;
                  wcnt  <= WW'(WAKE_LAT - 1);
                  idle  <= '0;
               end
            end
            RG_WAKING: begin
               if (wcnt <= WW'(1)) begin
                  state <= RG_AWAKE;
                  wcnt  <= '0;
                  idle  <= '0;
               end else begin
                  wcnt <= wcnt - WW'(1);
               end
            end
            RG_AWAKE: begin
               if (hit) begin
                  idle <= '0;
               end else if (limit_i != '0) begin
                  if (idle_nx >= {1'b0, limit_i}) begin
                     state <= RG_DROWSY;
                     idle  <= '0;
                  end else begin
                     idle <= idle_nx[IDLE_W-1:0];
                  end
               end
            end
            default: state <= RG_DROWSY;
         endcase
      end
   end

   AST_WAKE_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RG_WAKING && wcnt > WW'(1) && !force_i) |=> (wcnt == $past(wcnt) - WW'(1))); // R5

   AST_WAKE_KEEPS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RG_WAKING) |=> vdd_en_o); // R3

   AST_HIT_BLOCKS_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> awake_o); // R6

   AST_FORCE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      force_i |=> awake_o); // R8
endmodule

// File: rtl/drowsy_perf_cnt.sv
module drowsy_perf_cnt #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wake_i,
   input  logic             stall_i,
   output logic [CNT_W-1:0] wake_cnt_o,
   output logic [CNT_W-1:0] stall_cnt_o
);
   logic [CNT_W-1:0] wake_nx, stall_nx;

   if (SATURATE) begin : g_sat
      assign wake_nx  = (&wake_cnt_o)  ? wake_cnt_o  : wake_cnt_o  + 1'b1;
      assign stall_nx = (&stall_cnt_o) ? stall_cnt_o : stall_cnt_o + 1'b1;
   end else begin : g_wrap
      assign wake_nx  = wake_cnt_o  + 1'b1;
      assign stall_nx = stall_cnt_o + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_cnt_o  <= '0;
         stall_cnt_o <= '0;
      end else begin
         if (wake_i)  wake_cnt_o  <= wake_nx;
         if (stall_i) stall_cnt_o <= stall_nx;
      end
   end

   AST_STALL_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !stall_i |=> $stable(stall_cnt_o)); // R9

   AST_WAKE_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_i |=> $stable(wake_cnt_o)); // R9
endmodule

// File: rtl/drowsy_region_ctrl.sv
module drowsy_region_ctrl #(
   parameter int NUM_BLOCKS    = 64,
   parameter int REGION_BLOCKS = 8,
   parameter int WAKE_LAT      = 2,
   parameter int IDLE_W        = 16,
   parameter int CNT_W         = 16,
   parameter bit CNT_SATURATE  = 1'b1,
   localparam int BLK_W = $clog2(NUM_BLOCKS),
   localparam int OFS_W = $clog2(REGION_BLOCKS),
   localparam int RG_W  = BLK_W - OFS_W,
   localparam int NRG   = NUM_BLOCKS / REGION_BLOCKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [BLK_W-1:0]  req_block,
   output logic              req_ready,
   input  logic              force_awake,
   input  logic [IDLE_W-1:0] idle_limit,
   output logic [NRG-1:0]    region_vdd_en,
   output logic [CNT_W-1:0]  wake_count,
   output logic [CNT_W-1:0]  stall_count
);
   if ((1 << BLK_W) != NUM_BLOCKS) begin : g_chk_blocks
      $error("NUM_BLOCKS must be a power of two");
   end
   if ((1 << OFS_W) != REGION_BLOCKS) begin : g_chk_region
      $error("REGION_BLOCKS must be a power of two");
   end
   if (NRG < 2) begin : g_chk_count
      $error("at least two regions are required");
   end
   if (WAKE_LAT < 1) begin : g_chk_lat
      $error("WAKE_LAT must be at least 1");
   end
   if (IDLE_W < 1 || CNT_W < 1) begin : g_chk_width
      $error("counter widths must be positive");
   end

   logic [RG_W-1:0] rg_idx;
   logic [NRG-1:0]  rg_sel;
   logic [NRG-1:0]  rg_awake;
   logic [NRG-1:0]  rg_wake;
   logic            stall;

   drowsy_region_map #(
      .BLK_W (BLK_W),
      .OFS_W (OFS_W)
   ) map_i (
      .block_i  (req_block),
      .valid_i  (req_valid),
      .region_o (rg_idx),
      .select_o (rg_sel)
   );

   for (genvar r = 0; r < NRG; r++) begin : g_slot
      drowsy_region_slot #(
         .WAKE_LAT (WAKE_LAT),
         .IDLE_W   (IDLE_W)
      ) slot_i (
         .clk          (clk),
         .rst_n        (rst_n),
         .sel_i        (rg_sel[r]),
         .force_i      (force_awake),
         .limit_i      (idle_limit),
         .vdd_en_o     (region_vdd_en[r]),
         .awake_o      (rg_awake[r]),
         .wake_start_o (rg_wake[r])
      );
   end

   assign req_ready = force_awake || rg_awake[rg_idx];
   assign stall     = req_valid && !req_ready;

   drowsy_perf_cnt #(
      .CNT_W    (CNT_W),
      .SATURATE (CNT_SATURATE)
   ) perf_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wake_i      (|rg_wake),
      .stall_i     (stall),
      .wake_cnt_o  (wake_count),
      .stall_cnt_o (stall_count)
   );

   AST_STALL_RAISES_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> region_vdd_en[$past(rg_idx)]); // R3

   AST_ONE_WAKE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rg_wake)); // R2

   AST_FORCE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      force_awake |-> (req_ready && (&region_vdd_en))); // R8
endmodule

// File: tb/drowsy_region_ctrl_tb_top.sv
module drowsy_region_ctrl_tb_top;
   localparam int NB = 64;
   localparam int RB = 8;
   localparam int WL = 3;
   localparam int IW = 8;
   localparam int CW = 16;
   localparam int NR = NB / RB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [5:0]    req_block = '0;
   logic          req_ready;
   logic          force_awake = 1'b0;
   logic [IW-1:0] idle_limit = IW'(5);
   logic [NR-1:0] region_vdd_en;
   logic [CW-1:0] wake_count;
   logic [CW-1:0] stall_count;

   int n_run = 0;
   int n_fail = 0;
   int exp_wakes = 0;
   int exp_stalls = 0;
   int stall_run = 0;
   bit done = 1'b0;

   typedef struct {
      int    blk;
      int    exp;
      string tag;
   } item_t;
   item_t sb_q[$];

   always #10 clk = ~clk;

   drowsy_region_ctrl #(
      .NUM_BLOCKS    (NB),
      .REGION_BLOCKS (RB),
      .WAKE_LAT      (WL),
      .IDLE_W        (IW),
      .CNT_W         (CW)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_block     (req_block),
      .req_ready     (req_ready),
      .force_awake   (force_awake),
      .idle_limit    (idle_limit),
      .region_vdd_en (region_vdd_en),
      .wake_count    (wake_count),
      .stall_count   (stall_count)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: counts stall cycles and compares them on acceptance
   always @(negedge clk) begin
      if (rst_n && req_valid) begin
         if (req_ready) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "scoreboard empty on accept", 0, 1);
            end else begin
               item_t it;
               it = sb_q.pop_front();
               check(stall_run == it.exp, it.tag, stall_run, it.exp);
            end
            stall_run = 0;
         end else begin
            stall_run++;
         end
      end
   end

   // driver: gap idle cycles, then request; alt >= 0 switches block while stalled
   task automatic issue(input int blk, input int gap, input int alt, input int exp, input string tag);
      item_t it;
      if (gap > 0) begin
         repeat (gap) @(posedge clk);
         #1;
      end
      it.blk = blk;
      it.exp = exp;
      it.tag = tag;
      sb_q.push_back(it);
      exp_stalls += exp;
      if (exp > 0) exp_wakes++;
      req_block = 6'(blk);
      req_valid = 1'b1;
      forever begin
         @(negedge clk);
         if (req_ready) break;
         @(posedge clk);
         #1;
         if (alt >= 0) req_block = 6'(alt);
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(region_vdd_en == '0, "R1 supply enables after reset", int'(region_vdd_en), 0);
      check(wake_count == '0 && stall_count == '0, "R1 counters after reset",
            int'(wake_count) + int'(stall_count), 0);
      check(req_ready == 1'b0, "R1 ready low while drowsy", int'(req_ready), 0);
      @(posedge clk);
      #1;

      issue(3, 0, -1, WL, "R3 first access to drowsy region 0");
      @(negedge clk);
      check(region_vdd_en[0] == 1'b1, "R3 region 0 supply raised", int'(region_vdd_en[0]), 1);
      check(region_vdd_en[1] == 1'b0, "R2 region 1 untouched", int'(region_vdd_en[1]), 0);
      @(posedge clk);
      #1;
      issue(6, 0, -1, 0, "R4 awake region 0 ready at once");
      issue(7, 0, -1, 0, "R2 last block of region 0 shares wake");
      issue(9, 0, 14, WL, "R5 waking region 1 not restarted by block change");
      issue(15, 0, -1, 0, "R2 other block of region 1 no stall");
      issue(12, 4, -1, 0, "R6 still awake after limit-1 idle cycles");
      issue(12, 5, -1, WL, "R6 drowsy after limit idle cycles");
      @(negedge clk);
      check(region_vdd_en[0] == 1'b0, "R6 idle region 0 supply dropped", int'(region_vdd_en[0]), 0);
      @(posedge clk);
      #1;

      idle_limit = '0;
      issue(16, 0, -1, WL, "R7 wake region 2 with decay off");
      issue(23, 40, -1, 0, "R7 region 2 awake after 40 idle cycles");
      @(negedge clk);
      check(region_vdd_en[2] == 1'b1, "R7 region 2 supply kept", int'(region_vdd_en[2]), 1);
      @(posedge clk);
      #1;
      idle_limit = IW'(5);

      force_awake = 1'b1;
      @(negedge clk);
      check(&region_vdd_en, "R8 all supplies high under override", int'(region_vdd_en), (1 << NR) - 1);
      @(posedge clk);
      #1;
      issue(40, 0, -1, 0, "R8 drowsy region 5 ready under override");
      repeat (5) @(posedge clk);
      #1 force_awake = 1'b0;
      issue(56, 0, -1, 0, "R8 region 7 awake after override release");
      repeat (12) @(posedge clk);
      @(negedge clk);
      check(region_vdd_en == '0, "R8 regions decay after override release", int'(region_vdd_en), 0);

      check(int'(wake_count) == exp_wakes, "R9 wake_count", int'(wake_count), exp_wakes);
      check(int'(stall_count) == exp_stalls, "R9 stall_count", int'(stall_count), exp_stalls);
      check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule